// File: doc/BRIEF.md
# Two-Input Two-Output Packet Switch with Shared Statistics

The block moves 32-bit packet words from two input queues to two output queues. Bit 0 of each word picks the output, and bit 1 marks the packet as one to be counted. Both sides of the block are valid/ready streams. An input word is taken on a clock edge where valid and ready are both high. An output word leaves on an edge where valid and ready are both high. A producer must hold valid and the data steady until the word is taken. A consumer may drop ready at any time, and the block then holds its output word.

Each input queue can hand its head packet across in a single atomic step. In that step the input pops, the chosen output pushes and, for a flagged packet, the shared 16-bit counter adds one. All three happen together in the same clock or none of them happen. There is no staging register between the queues. The two inputs compete for an output queue and for the counter. A fixed-priority parameter decides each conflict, and the losing input tries again on the next clock with nothing changed. When the two inputs need no common resource, both move in the same clock.

Top module: `pkt_switch2x2`

## Requirements
- R1: A packet with bit 0 equal to 0 is delivered on output 0. A packet with bit 0 equal to 1 is delivered on output 1.
- R2: The counter `stat_count` adds exactly one for every transferred packet whose bit 1 is set. It wraps from 16'hFFFF to 0.
- R3: No more than one packet enters a given output queue per clock.
- R4: The counter never advances by more than one per clock, even when both heads are flagged.
- R5: A head packet moves only if its input queue is non-empty and its target output queue has room. A blocked input keeps its head and does not hold up the other input.
- R6: If both heads can move, target different outputs and are not both flagged, both move in the same clock.
- R7: On a conflict (same output, or both flagged) the input named by parameter `PRIO` moves first. The default is input 0. The other input moves on a later clock.
- R8: Packets from one input to one output leave in the order they arrived, with none lost and none duplicated.
- R9: Synchronous reset empties all queues and clears the counter. After reset both outputs are invalid and both inputs are ready.
- R10: Each queue holds 4 words. An input's ready drops once its own queue is full and the head cannot leave, so a blocked output back-pressures its inputs after 8 accepted words.
- R11: The minimum latency is two clocks: a word accepted on edge k is shown on its output after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | Input 0 word valid |
| in0_ready | output | 1 | Input 0 can accept |
| in0_data | input | 32 | Input 0 packet word |
| in1_valid | input | 1 | Input 1 word valid |
| in1_ready | output | 1 | Input 1 can accept |
| in1_data | input | 32 | Input 1 packet word |
| out0_valid | output | 1 | Output 0 word valid |
| out0_ready | input | 1 | Consumer of output 0 can take |
| out0_data | output | 32 | Output 0 packet word |
| out1_valid | output | 1 | Output 1 word valid |
| out1_ready | input | 1 | Consumer of output 1 can take |
| out1_data | output | 32 | Output 1 packet word |
| stat_count | output | 16 | Count of transferred flagged packets |

## Verification
The in-line assertions check the following on every cycle:
- at most one push into each output queue and at most one counter step;
- no grant without a head and room;
- the winner on a conflict;
- parallel grants for independent heads;
- queue occupancy bounds;
- the routing bit on both outputs.

Only the bench's scenarios can show per-flow ordering, loss and duplication, the two-clock latency, the exact back-pressure depth, and the counter's agreement with delivered flagged traffic across a full wrap.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int PKT_W    = 32;
  localparam int DEST_BIT = 0;
  localparam int CNT_BIT  = 1;
  typedef logic [PKT_W-1:0] pkt_t;
endpackage

// File: rtl/sw_fifo.sv
module sw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] used;
  logic          push, pop;

  assign in_ready  = (used != CW'(DEPTH));
  assign out_valid = (used != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= in_data;
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      used <= used + CW'(push) - CW'(pop);
    end
  end

  // R10: occupancy stays within the configured depth
  a_r10_bound: assert property (@(posedge clk) disable iff (rst) used <= CW'(DEPTH));
  // R8: a push into a full queue never lands (occupancy held or reduced)
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (used == CW'(DEPTH) && !out_ready) |=> (used == CW'(DEPTH)));
endmodule

// File: rtl/sw_arbiter.sv
module sw_arbiter #(
  parameter int PRIO = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] head_valid,
  input  logic [1:0] head_dest,
  input  logic [1:0] head_flag,
  input  logic [1:0] out_room,
  output logic [1:0] grant
);
  localparam int LOSE = 1 - PRIO;

  logic [1:0] want;
  logic       clash;

  always_comb begin
    for (int i = 0; i < 2; i++) want[i] = head_valid[i] && out_room[head_dest[i]];
    clash = want[0] && want[1] &&
            ((head_dest[0] == head_dest[1]) || (head_flag[0] && head_flag[1]));
    grant       = '0;
    grant[PRIO] = want[PRIO];
    grant[LOSE] = want[LOSE] && !clash;
  end

  // R3: one push per output queue per clock
  a_r3_one_per_output: assert property (@(posedge clk) disable iff (rst)
    !(grant[0] && grant[1] && head_dest[0] == head_dest[1]));
  // R4: one counter step per clock
  a_r4_one_count: assert property (@(posedge clk) disable iff (rst)
    !(grant[0] && grant[1] && head_flag[0] && head_flag[1]));
  // R5: a grant needs a head and room at its target
  a_r5_grant_ok0: assert property (@(posedge clk) disable iff (rst)
    grant[0] |-> (head_valid[0] && out_room[head_dest[0]]));
  a_r5_grant_ok1: assert property (@(posedge clk) disable iff (rst)
    grant[1] |-> (head_valid[1] && out_room[head_dest[1]]));
  // R6: independent heads both move
  a_r6_parallel: assert property (@(posedge clk) disable iff (rst)
    (head_valid == 2'b11 && out_room == 2'b11 && head_dest[0] != head_dest[1] &&
     !(head_flag[0] && head_flag[1])) |-> (grant == 2'b11));
  // R7: priority input wins a shared output
  a_r7_winner: assert property (@(posedge clk) disable iff (rst)
    (head_valid == 2'b11 && head_dest[0] == head_dest[1] && out_room[head_dest[0]])
    |-> (grant[PRIO] && !grant[LOSE]));
endmodule

// File: rtl/sw_stat_counter.sv
module sw_stat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R2: counter moves by exactly one with wrap when asked, else holds
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> (count == $past(count) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/pkt_switch2x2.sv
module pkt_switch2x2
  import sw_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int PRIO   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in0_valid,
  output logic             in0_ready,
  input  logic [PKT_W-1:0] in0_data,
  input  logic             in1_valid,
  output logic             in1_ready,
  input  logic [PKT_W-1:0] in1_data,
  output logic             out0_valid,
  input  logic             out0_ready,
  output logic [PKT_W-1:0] out0_data,
  output logic             out1_valid,
  input  logic             out1_ready,
  output logic [PKT_W-1:0] out1_data,
  output logic [CNT_W-1:0] stat_count
);
  logic [1:0] src_valid, src_ready, dst_valid, dst_ready;
  pkt_t       src_data [2];
  pkt_t       dst_data [2];

  logic [1:0] hd_valid, hd_dest, hd_flag, grant;
  pkt_t       hd_data [2];

  logic [1:0] enq, room;
  pkt_t       enq_data [2];

  assign src_valid = {in1_valid, in0_valid};
  assign src_data[0] = in0_data;
  assign src_data[1] = in1_data;
  assign in0_ready = src_ready[0];
  assign in1_ready = src_ready[1];
  assign dst_ready = {out1_ready, out0_ready};
  assign out0_valid = dst_valid[0];
  assign out1_valid = dst_valid[1];
  assign out0_data  = dst_data[0];
  assign out1_data  = dst_data[1];

  for (genvar i = 0; i < 2; i++) begin : g_in
    sw_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst(rst),
      .in_valid(src_valid[i]), .in_ready(src_ready[i]), .in_data(src_data[i]),
      .out_valid(hd_valid[i]), .out_ready(grant[i]), .out_data(hd_data[i]));
    assign hd_dest[i] = hd_data[i][DEST_BIT];
    assign hd_flag[i] = hd_data[i][CNT_BIT];
  end

  sw_arbiter #(.PRIO(PRIO)) u_arb (
    .clk(clk), .rst(rst), .head_valid(hd_valid), .head_dest(hd_dest),
    .head_flag(hd_flag), .out_room(room), .grant(grant));

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic from0, from1;
    assign from0       = grant[0] && (hd_dest[0] == 1'(o));
    assign from1       = grant[1] && (hd_dest[1] == 1'(o));
    assign enq[o]      = from0 || from1;
    assign enq_data[o] = from0 ? hd_data[0] : hd_data[1];
    sw_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst(rst),
      .in_valid(enq[o]), .in_ready(room[o]), .in_data(enq_data[o]),
      .out_valid(dst_valid[o]), .out_ready(dst_ready[o]), .out_data(dst_data[o]));
  end

  sw_stat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(|(grant & hd_flag)), .count(stat_count));

  // R1: each output carries only packets with its own destination bit
  a_r1_route0: assert property (@(posedge clk) disable iff (rst)
    out0_valid |-> (out0_data[DEST_BIT] == 1'b0));
  a_r1_route1: assert property (@(posedge clk) disable iff (rst)
    out1_valid |-> (out1_data[DEST_BIT] == 1'b1));
  // R5: a popped input head always lands in its target output queue
  a_r5_atomic: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && !grant[1]) |-> $onehot(enq));
endmodule

// File: tb/pkt_switch2x2_bench.sv
module pkt_switch2x2_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  iv = '0, ordy = '0, irdy, ov;
  logic [31:0] id [2];
  logic [31:0] od [2];
  logic [15:0] stat_count;

  always #5 clk = ~clk;

  pkt_switch2x2 u_pkt_switch2x2 (
    .clk(clk), .rst(rst),
    .in0_valid(iv[0]), .in0_ready(irdy[0]), .in0_data(id[0]),
    .in1_valid(iv[1]), .in1_ready(irdy[1]), .in1_data(id[1]),
    .out0_valid(ov[0]), .out0_ready(ordy[0]), .out0_data(od[0]),
    .out1_valid(ov[1]), .out1_ready(ordy[1]), .out1_data(od[1]),
    .stat_count(stat_count));

  // vector table: {src, expected output, word}; bit2 of word = src
  localparam logic [33:0] TBL [8] = '{
    {1'b0, 1'b0, 32'h1111_0000}, {1'b0, 1'b1, 32'h2222_0001},
    {1'b0, 1'b0, 32'h3333_0002}, {1'b0, 1'b1, 32'h4444_0003},
    {1'b1, 1'b0, 32'h5555_0004}, {1'b1, 1'b1, 32'h6666_0005},
    {1'b1, 1'b0, 32'h7777_0006}, {1'b1, 1'b1, 32'h8888_0007}};

  int n_chk = 0, n_fail = 0;
  logic [1:0]  nv = '0, nr = '0, acc, obs_v;
  logic [31:0] nd [2];
  logic [31:0] obs_d [2];
  logic [31:0] sbq [2][2][1024];
  int wp [2][2];
  int rp [2][2];
  int dl [2];
  logic [15:0] seq [2];
  logic [15:0] fl_cnt = '0;
  bit sb_on = 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int src, input bit dest, input bit flag);
    logic [31:0] w;
    w = {seq[src], 13'd0, 1'(src), flag, dest};
    seq[src] = seq[src] + 1'b1;
    return w;
  endfunction

  // one clock: drive at negedge, observe just before the next posedge
  task automatic step();
    @(negedge clk);
    iv = nv; ordy = nr; id[0] = nd[0]; id[1] = nd[1];
    #4;
    for (int i = 0; i < 2; i++) begin
      acc[i] = iv[i] && irdy[i];
      if (acc[i] && sb_on) begin
        sbq[i][id[i][0]][wp[i][id[i][0]] % 1024] = id[i];
        wp[i][id[i][0]]++;
      end
    end
    for (int o = 0; o < 2; o++) begin
      obs_v[o] = ov[o];
      obs_d[o] = od[o];
      if (ov[o] && ordy[o]) begin
        int s;
        dl[o]++;
        if (od[o][1]) fl_cnt = fl_cnt + 1'b1;
        if (sb_on) begin
          s = int'(od[o][2]);
          chk(od[o][0] == 1'(o), "R1 route", od[o][0], o);
          chk(rp[s][o] < wp[s][o], "R8 no duplicate", rp[s][o], wp[s][o]);
          chk(od[o] == sbq[s][o][rp[s][o] % 1024], "R8 order", od[o], sbq[s][o][rp[s][o] % 1024]);
          rp[s][o]++;
        end
      end
    end
  endtask

  task automatic do_reset();
    nv = '0; nr = '0;
    @(negedge clk); rst = 1'b1; iv = '0; ordy = '0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 2; a++) begin
      dl[a] = 0; seq[a] = '0;
      for (int b = 0; b < 2; b++) begin wp[a][b] = 0; rp[a][b] = 0; end
    end
    fl_cnt = '0;
  endtask

  task automatic drain();
    nv = '0; nr = 2'b11;
    repeat (16) step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    id[0] = '0; id[1] = '0; nd[0] = '0; nd[1] = '0;
    do_reset();
    #4;
    chk(stat_count == 16'd0, "R9 count cleared", stat_count, 0);
    chk(ov == 2'b00, "R9 outputs empty", ov, 0);
    chk(irdy == 2'b11, "R9 inputs ready", irdy, 3);

    // table walk: one packet at a time, checked two clocks after acceptance (R11, R1)
    for (int k = 0; k < 8; k++) begin
      int s, e;
      s = int'(TBL[k][33]); e = int'(TBL[k][32]);
      nr = 2'b11; nv = '0; nv[s] = 1'b1; nd[s] = TBL[k][31:0];
      step();
      nv = '0;
      step();
      chk(obs_v == 2'b00, "R11 not yet out", obs_v, 0);
      step();
      chk(obs_v[e] && obs_d[e] == TBL[k][31:0], "R11 R1 table word", obs_d[e], TBL[k][31:0]);
      chk(!obs_v[1-e], "R1 other output idle", obs_v[1-e], 0);
      step();
    end
    drain();
    chk(stat_count == 16'd4, "R2 table flagged count", stat_count, 4);

    // R7 / R3: both target output 0, input 0 first
    do_reset();
    begin
      logic [31:0] p0, p1;
      p0 = mk(0, 1'b0, 1'b0); p1 = mk(1, 1'b0, 1'b0);
      nr = 2'b11; nv = 2'b11; nd[0] = p0; nd[1] = p1;
      step(); nv = '0; step(); step();
      chk(obs_v[0] && obs_d[0] == p0, "R7 priority input first", obs_d[0], p0);
      step();
      chk(obs_v[0] && obs_d[0] == p1, "R3 loser next clock", obs_d[0], p1);
    end
    drain();

    // R4: both flagged, different outputs
    do_reset();
    nr = 2'b11; nv = 2'b11; nd[0] = mk(0, 1'b0, 1'b1); nd[1] = mk(1, 1'b1, 1'b1);
    step(); nv = '0; step(); step();
    chk(stat_count == 16'd1 && obs_v == 2'b01, "R4 one count per clock", {stat_count, obs_v}, {16'd1, 2'b01});
    step();
    chk(stat_count == 16'd2 && obs_v[1], "R4 second count", stat_count, 2);
    drain();

    // R6: independent heads move together
    do_reset();
    nr = 2'b11; nv = 2'b11; nd[0] = mk(0, 1'b0, 1'b1); nd[1] = mk(1, 1'b1, 1'b0);
    step(); nv = '0; step(); step();
    chk(obs_v == 2'b11, "R6 both outputs same clock", obs_v, 3);
    drain();

    // R5 / R10: output 0 blocked, input 1 to output 1 still flows
    do_reset();
    begin
      int got0 = 0;
      nr = 2'b10; nv = 2'b11; nd[0] = mk(0, 1'b0, 1'b0); nd[1] = mk(1, 1'b1, 1'b0);
      for (int c = 0; c < 14; c++) begin
        step();
        if (acc[0]) begin got0++; nd[0] = mk(0, 1'b0, 1'b0); end
        if (acc[1]) nv[1] = 1'b0;
      end
      chk(got0 == 8, "R10 accepted before back-pressure", got0, 8);
      chk(irdy[0] == 1'b0, "R10 input 0 not ready", irdy[0], 0);
      chk(dl[1] == 1, "R5 other input unaffected", dl[1], 1);
    end
    drain();
    chk(rp[0][0] == 8, "R8 blocked flow delivered", rp[0][0], 8);

    // random traffic with random back-pressure
    do_reset();
    nv = '0;
    for (int c = 0; c < 800; c++) begin
      for (int i = 0; i < 2; i++)
        if (!nv[i] && ($urandom % 3 != 0)) begin
          nv[i] = 1'b1; nd[i] = mk(i, 1'($urandom), 1'($urandom));
        end
      nr = 2'($urandom);
      step();
      for (int i = 0; i < 2; i++) if (acc[i]) nv[i] = 1'b0;
    end
    drain();
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        chk(rp[a][b] == wp[a][b], "R8 nothing lost", rp[a][b], wp[a][b]);
    chk(stat_count == fl_cnt, "R2 count equals flagged delivered", stat_count, fl_cnt);

    // R2 wrap: 65538 flagged packets
    do_reset();
    sb_on = 1'b0;
    begin
      int pushed = 0;
      nr = 2'b11; nv = 2'b01; nd[0] = mk(0, 1'b0, 1'b1);
      while (pushed < 65538) begin
        step();
        if (acc[0]) begin
          pushed++;
          nd[0] = mk(0, 1'(pushed), 1'b1);
          if (pushed == 65538) nv = '0;
        end
      end
    end
    drain();
    chk(stat_count == 16'd2, "R2 wrap", stat_count, 2);
    chk(stat_count == fl_cnt, "R2 wrap matches delivered", stat_count, fl_cnt);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule